// File: doc/BRIEF.md
# Link Capability and Status Reconciler

This block produces the link-related register values for a root or downstream port of a serial point-to-point interconnect. Two static configuration inputs give the port's maximum lane width and maximum speed code. From them the block derives four values: the link capabilities word, a supported-speeds vector, the target-speed field and the capability bits for bandwidth notification and data-link-active reporting. These values follow the configuration inputs combinationally.

The link status word is held in a register. Reset fills its width and speed fields from the capability fields. After that, a one-cycle sync strobe recomputes the two fields from a snapshot of the downstream device's reported status. If no device is present, the fields are copied from the capability. If a device is present, each reported field is clamped to the port's capability, and a reported zero is raised to the minimum code. Only those two fields change on a sync. The other status bits keep their values. Link training, link signalling and the configuration access path are outside this block.

Speed codes are 1, 2, 3 and 4 for 2.5, 5, 8 and 16 GT/s. Width is a 6-bit lane count, with x1 coded as 1.

Top module: `lcs_reconciler`

## Requirements
- R1: Capability bit 21 (bandwidth notification capable) is 1 exactly when the configured width is above 1 or the configured speed code is above 1. Capability bits [3:0] carry the configured speed code and bits [9:4] carry the configured width. All other capability bits are 0.
- R2: When the configured speed code is above 1, capability bit 20 (link-active reporting capable) is 1 and status bit 13 (link active) is 1. Otherwise both bits are 0.
- R3: The target-speed output equals the configured speed code when that code is above 1, and is 0 otherwise.
- R4: The supported-speeds vector has bit 0 for 2.5, bit 1 for 5, bit 2 for 8 and bit 3 for 16 GT/s. When the speed code is above 2, bits 2:0 are set. Bit 3 is also set when the speed code is above 3. When the speed code is 2 or less, the vector is 0.
- R5: While reset is asserted, the status register loads width [9:4] and speed [3:0] from the capability fields, and bit 13 per R2. A sync strobe during reset has no effect.
- R6: A sync with no device present sets the status width and speed fields to the capability width and speed.
- R7: A sync with a device present sets status width to the reported width (snapshot bits [9:4]). A reported width of 0 becomes 1, and a reported width above the capability width becomes the capability width.
- R8: A sync with a device present sets status speed to the reported speed (snapshot bits [3:0]). A reported speed of 0 becomes 1, and a reported speed above the capability speed becomes the capability speed.
- R9: A sync changes only status bits [9:0]. Snapshot bits [15:10] are ignored, and status bits [15:10] keep their values.
- R10: A sync result appears on the status output one clock after the strobe. Without a strobe, the status output holds its value whatever the snapshot does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | 6 | Configured maximum lane width |
| cfg_speed | input | 4 | Configured maximum speed code |
| sync_req | input | 1 | One-cycle strobe to recompute status |
| dn_present | input | 1 | Downstream device present |
| dn_status | input | 16 | Downstream device reported status snapshot |
| link_cap | output | 32 | Link capabilities word |
| speed_vec | output | 4 | Supported-speeds vector |
| target_speed | output | 4 | Target link speed field |
| link_status | output | 16 | Registered link status word |

## Verification
The width clamp and the speed clamp work on separate fields but act in the same sync. The bench therefore sends snapshots where one field is raised from zero while the other is cut to the capability, and the resulting status word is compared as a whole. A sync strobe is also held high through a reset with a conflicting snapshot. The status after release must carry only the capability-derived reset values, showing that reset takes priority over the strobe.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
    localparam int SPD_W        = 4;
    localparam int WID_W        = 6;
    localparam int CAP_W        = 32;
    localparam int STA_W        = 16;
    localparam int VEC_W        = 4;
    localparam int FLD_SPD_LSB  = 0;
    localparam int FLD_WID_LSB  = 4;
    localparam int STA_DLLA_BIT = 13;
    localparam int CAP_DLRC_BIT = 20;
    localparam int CAP_BWN_BIT  = 21;
    localparam int SPD_2G5      = 1;
    localparam int SPD_5G       = 2;
    localparam int WID_X1       = 1;

    typedef enum logic [1:0] {
        CLAMP_PASS     = 2'd0,
        CLAMP_TO_CAP   = 2'd1,
        CLAMP_TO_MIN   = 2'd2,
        CLAMP_FROM_CAP = 2'd3
    } clamp_kind_e;
endpackage

// File: rtl/lcs_cap_gen.sv
module lcs_cap_gen
    import lcs_pkg::*;
#(
    parameter int SW = SPD_W,
    parameter int WW = WID_W,
    parameter int CW = CAP_W,
    parameter int VW = VEC_W
) (
    input  logic [WW-1:0] cfg_width,
    input  logic [SW-1:0] cfg_speed,
    output logic [CW-1:0] cap_word,
    output logic [VW-1:0] speed_vec,
    output logic [SW-1:0] target_spd,
    output logic          dll_force
);
    logic above_base;
    logic wide;

    assign above_base = (int'(cfg_speed) > SPD_2G5);
    assign wide       = (int'(cfg_width) > WID_X1);
    assign dll_force  = above_base;
    assign target_spd = above_base ? cfg_speed : '0;

    always_comb begin
        cap_word = '0;
        cap_word[FLD_SPD_LSB +: SW] = cfg_speed;
        cap_word[FLD_WID_LSB +: WW] = cfg_width;
        cap_word[CAP_DLRC_BIT]      = above_base;
        cap_word[CAP_BWN_BIT]       = above_base | wide;
    end

    // Bit i stands for speed code i+1; the vector is only filled above 5 GT/s.
    for (genvar i = 0; i < VW; i++) begin : g_vec
        assign speed_vec[i] = (int'(cfg_speed) > SPD_5G) && (int'(cfg_speed) > i);
    end
endmodule

// File: rtl/lcs_clamp.sv
module lcs_clamp
    import lcs_pkg::*;
#(
    parameter int W        = 4,
    parameter int MIN_CODE = 1
) (
    input  logic [W-1:0]  rpt,
    input  logic [W-1:0]  cap,
    input  logic          present,
    output logic [W-1:0]  res,
    output clamp_kind_e   kind
);
    always_comb begin
        if (!present)          kind = CLAMP_FROM_CAP;
        else if (rpt == '0)    kind = CLAMP_TO_MIN;
        else if (rpt > cap)    kind = CLAMP_TO_CAP;
        else                   kind = CLAMP_PASS;
    end

    always_comb begin
        unique case (kind)
            CLAMP_PASS:     res = rpt;
            CLAMP_TO_MIN:   res = W'(MIN_CODE);
            CLAMP_TO_CAP,
            CLAMP_FROM_CAP: res = cap;
            default:        res = cap;
        endcase
    end
endmodule

// File: rtl/lcs_reconciler.sv
module lcs_reconciler
    import lcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WID_W-1:0] cfg_width,
    input  logic [SPD_W-1:0] cfg_speed,
    input  logic             sync_req,
    input  logic             dn_present,
    input  logic [STA_W-1:0] dn_status,
    output logic [CAP_W-1:0] link_cap,
    output logic [VEC_W-1:0] speed_vec,
    output logic [SPD_W-1:0] target_speed,
    output logic [STA_W-1:0] link_status
);
    localparam int LOW_W = FLD_WID_LSB + WID_W;

    logic             dll_force;
    logic [WID_W-1:0] wid_res;
    logic [SPD_W-1:0] spd_res;
    clamp_kind_e      wid_kind;
    clamp_kind_e      spd_kind;
    logic [STA_W-1:0] sta_q;
    logic [STA_W-1:0] sta_d;
    logic [STA_W-1:0] sta_init;

    lcs_cap_gen #(.SW(SPD_W), .WW(WID_W), .CW(CAP_W), .VW(VEC_W)) u_cap (
        .cfg_width  (cfg_width),
        .cfg_speed  (cfg_speed),
        .cap_word   (link_cap),
        .speed_vec  (speed_vec),
        .target_spd (target_speed),
        .dll_force  (dll_force)
    );

    lcs_clamp #(.W(WID_W), .MIN_CODE(WID_X1)) u_wid (
        .rpt     (dn_status[FLD_WID_LSB +: WID_W]),
        .cap     (link_cap[FLD_WID_LSB +: WID_W]),
        .present (dn_present),
        .res     (wid_res),
        .kind    (wid_kind)
    );

    lcs_clamp #(.W(SPD_W), .MIN_CODE(SPD_2G5)) u_spd (
        .rpt     (dn_status[FLD_SPD_LSB +: SPD_W]),
        .cap     (link_cap[FLD_SPD_LSB +: SPD_W]),
        .present (dn_present),
        .res     (spd_res),
        .kind    (spd_kind)
    );

    always_comb begin
        sta_init = '0;
        sta_init[FLD_SPD_LSB +: SPD_W] = link_cap[FLD_SPD_LSB +: SPD_W];
        sta_init[FLD_WID_LSB +: WID_W] = link_cap[FLD_WID_LSB +: WID_W];
        sta_init[STA_DLLA_BIT]         = dll_force;
    end

    always_comb begin
        sta_d = sta_q;
        if (sync_req) begin
            sta_d[FLD_SPD_LSB +: SPD_W] = spd_res;
            sta_d[FLD_WID_LSB +: WID_W] = wid_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sta_q <= sta_init;
        else        sta_q <= sta_d;
    end

    assign link_status = sta_q;

    logic unused_kinds;
    assign unused_kinds = ^{wid_kind, spd_kind, LOW_W[0]};
endmodule

// File: rtl/lcs_reconciler_chk.sv
module lcs_reconciler_chk
    import lcs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [WID_W-1:0] cfg_width,
    input logic [SPD_W-1:0] cfg_speed,
    input logic             sync_req,
    input logic             dn_present,
    input logic [CAP_W-1:0] link_cap,
    input logic [VEC_W-1:0] speed_vec,
    input logic [SPD_W-1:0] target_speed,
    input logic [STA_W-1:0] link_status
);
    AST_BWN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        link_cap[CAP_BWN_BIT] == ((cfg_width > 6'd1) || (cfg_speed > 4'd1))); // R1
    AST_DLL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        link_cap[CAP_DLRC_BIT] == link_status[STA_DLLA_BIT]); // R2
    AST_TLS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (target_speed == '0) || (target_speed == link_cap[3:0])); // R3
    AST_VEC_DENSE: assert property (@(posedge clk) disable iff (!rst_n)
        speed_vec[3] |-> (speed_vec[2:0] == 3'b111)); // R4
    AST_NOPRES_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && !dn_present) |=> (link_status[9:0] == $past(link_cap[9:0]))); // R6
    AST_WID_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (link_cap[9:4] != '0) |-> (link_status[9:4] != '0 && link_status[9:4] <= link_cap[9:4])); // R7
    AST_SPD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (link_cap[3:0] != '0) |-> (link_status[3:0] != '0 && link_status[3:0] <= link_cap[3:0])); // R8
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> $stable(link_status[15:10])); // R9
    AST_NO_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_req |=> $stable(link_status)); // R10
endmodule

bind lcs_reconciler lcs_reconciler_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_width    (cfg_width),
    .cfg_speed    (cfg_speed),
    .sync_req     (sync_req),
    .dn_present   (dn_present),
    .link_cap     (link_cap),
    .speed_vec    (speed_vec),
    .target_speed (target_speed),
    .link_status  (link_status)
);

// File: tb/tb_lcs_reconciler.sv
`timescale 1ns/1ps
module tb_lcs_reconciler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_width = 6'd1;
    logic [3:0]  cfg_speed = 4'd1;
    logic        sync_req = 1'b0;
    logic        dn_present = 1'b0;
    logic [15:0] dn_status = '0;
    logic [31:0] link_cap;
    logic [3:0]  speed_vec;
    logic [3:0]  target_speed;
    logic [15:0] link_status;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int          due;
        logic [15:0] val;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    lcs_reconciler dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_speed(cfg_speed),
        .sync_req(sync_req), .dn_present(dn_present), .dn_status(dn_status),
        .link_cap(link_cap), .speed_vec(speed_vec), .target_speed(target_speed),
        .link_status(link_status)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    // Monitor: compares queued status expectations in their due cycle.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            chk(exp_q[0].req, {16'd0, link_status}, {16'd0, exp_q[0].val});
            void'(exp_q.pop_front());
        end
    end

    function automatic logic [15:0] sta_of(bit dll, int w, int s);
        return (16'(dll) << 13) | 16'((w & 63) << 4) | 16'(s & 15);
    endfunction

    function automatic int clampv(int rpt, int cap);
        if (rpt == 0) return 1;
        if (rpt > cap) return cap;
        return rpt;
    endfunction

    task automatic push(int due, logic [15:0] v, string req);
        exp_t e;
        e.due = due; e.val = v; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic set_cfg(int w, int s);
        logic [31:0] ec;
        bit dll;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_width = 6'(w);
        cfg_speed = 4'(s);
        sync_req = 1'b1;              // strobe during reset must be ignored (R5)
        dn_present = 1'b1;
        dn_status = 16'hFFFF;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        sync_req = 1'b0;
        dll = (s > 1);
        ec = 32'(s) | (32'(w) << 4) | (32'(dll) << 20) | (32'((w > 1) || (s > 1)) << 21);
        chk("R1 cap word", link_cap, ec);
        chk("R2 dll cap bit", {31'd0, link_cap[20]}, {31'd0, dll});
        chk("R3 target speed", {28'd0, target_speed}, (s > 1) ? 32'(s) : 32'd0);
        chk("R4 speed vec", {28'd0, speed_vec},
            (s > 3) ? 32'hF : (s > 2) ? 32'h7 : 32'h0);
        push(cyc + 1, sta_of(dll, w, s), "R5 reset load");
    endtask

    task automatic do_sync(bit pres, logic [15:0] snap, logic [15:0] expv, string req);
        @(negedge clk);
        sync_req = 1'b1;
        dn_present = pres;
        dn_status = snap;
        push(cyc + 1, expv, req);
        @(negedge clk);
        sync_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        set_cfg(1, 1);
        do_sync(1'b0, 16'h0000, sta_of(0, 1, 1), "R6 no device");
        do_sync(1'b1, 16'h0000, sta_of(0, 1, 1), "R7 R8 zero raised");

        set_cfg(16, 4);
        do_sync(1'b1, 16'hFC00 | 16'(8 << 4) | 16'd2, sta_of(1, 8, 2), "R9 upper ignored");
        do_sync(1'b1, 16'(32 << 4) | 16'd7, sta_of(1, 16, 4), "R7 R8 to cap");
        do_sync(1'b1, 16'h0000, sta_of(1, 1, 1), "R7 R8 to min");
        do_sync(1'b1, 16'd9, sta_of(1, clampv(0, 16), clampv(9, 4)), "R7 R8 mixed");
        do_sync(1'b1, 16'(5 << 4) | 16'd3, sta_of(1, 5, 3), "R10 latency");
        @(negedge clk);
        dn_present = 1'b1;
        dn_status = 16'(2 << 4) | 16'd1;
        push(cyc + 1, sta_of(1, 5, 3), "R10 hold 1");
        push(cyc + 2, sta_of(1, 5, 3), "R10 hold 2");
        push(cyc + 3, sta_of(1, 5, 3), "R10 hold 3");
        repeat (3) @(negedge clk);
        do_sync(1'b0, 16'h3FFF, sta_of(1, 16, 4), "R6 no device wide");

        set_cfg(4, 3);
        do_sync(1'b1, 16'(6 << 4) | 16'd2, sta_of(1, 4, 2), "R7 width cap");
        set_cfg(1, 2);
        do_sync(1'b1, 16'(1 << 4) | 16'd3, sta_of(1, 1, 2), "R8 speed cap");
        set_cfg(2, 1);
        do_sync(1'b1, 16'hFC00 | 16'(2 << 4) | 16'd1, sta_of(0, 2, 1), "R9 keep low dll");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule